// File: doc/BRIEF.md
# Condition and Overflow Flag Unit

This block holds the two flag registers of a fixed-point integer pipeline. The first is a 32-bit condition word. It is split into eight 4-bit fields, and each field carries less-than, greater-than, equal and summary-overflow bits. The second is an exception word with three live bits: summary overflow, overflow and carry. Each ALU instruction chooses which flags it touches. An overflow-enable bit lets the overflow state change, a record bit rewrites field 0, and a carry-enable bit marks instructions that produce a carry.

The unit also runs three move commands:
- copy one condition field onto another;
- load any chosen set of condition fields from a general register word;
- load the exception word from a general register word.

One command is accepted per clock while `op_valid` is high. Its effect shows on `cr_q` and `xer_q` after the next rising edge.

Summary overflow is sticky, and a small state machine with two states holds it:
- **SO_CLEAR**: summary overflow reads 0. The transition *raise* goes to SO_SET on an ALU operation that has overflow-enable and overflow both set. The transition *load-set* goes to SO_SET on an exception-word load with bit 31 set.
- **SO_SET**: summary overflow reads 1. Its only way out is the transition *load-clear*, back to SO_CLEAR, on an exception-word load with bit 31 clear.

All other commands keep the current state.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, both `cr_q` and `xer_q` read 0.
- R2: An ALU operation with `alu_ca_en`=1 writes `alu_carry` into the carry bit (`xer_q` bit 29), whatever the value of `alu_oe`. With `alu_ca_en`=0 the carry bit keeps its value.
- R3: An ALU operation with `alu_oe`=1 and `alu_ovf`=1 sets summary overflow (`xer_q` bit 31). Once set, it stays 1 through every ALU operation, field copy and condition load.
- R4: An ALU operation with `alu_oe`=1 overwrites the overflow bit (`xer_q` bit 30) with `alu_ovf`, including back to 0. With `alu_oe`=0, neither the overflow bit nor summary overflow changes.
- R5: An ALU operation with `alu_rc`=0 leaves `cr_q` unchanged. An ALU operation never changes fields 1 to 7.
- R6: An ALU operation with `alu_rc`=1 writes field 0 (`cr_q[31:28]`) as {LT, GT, EQ, SO}. LT, GT and EQ come from comparing `alu_result`, taken as signed, with zero. SO is the summary overflow value after the same instruction's update.
- R7: A field copy (`op_code`=01) writes the old value of field `src_field` into field `dst_field`, and every other field keeps its value. Field n occupies `cr_q[31-4n:28-4n]`.
- R8: A condition load (`op_code`=10) sets field n to the same bit positions of `gpr_data` for each n with `field_mask[n]`=1. Fields whose mask bit is 0 keep their value.
- R9: An exception load (`op_code`=11) sets summary overflow, overflow and carry from `gpr_data` bits 31, 30 and 29. This is the only way summary overflow returns to 0. `xer_q` bits 28:0 always read 0.
- R10: While `op_valid` is low, `cr_q` and `xer_q` hold their values whatever the other inputs are.
- R11: An ALU operation is `op_code`=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A command is present this cycle |
| op_code | input | 2 | 00 ALU update, 01 field copy, 10 condition load, 11 exception load |
| alu_result | input | 32 | ALU result compared with zero for field 0 |
| alu_carry | input | 1 | Carry out of the ALU |
| alu_ca_en | input | 1 | The instruction produces a carry |
| alu_ovf | input | 1 | Signed overflow of the ALU |
| alu_oe | input | 1 | Overflow-enable bit of the instruction |
| alu_rc | input | 1 | Record bit: update field 0 |
| src_field | input | 3 | Source field index for a copy |
| dst_field | input | 3 | Destination field index for a copy |
| field_mask | input | 8 | Bit n selects field n for a condition load |
| gpr_data | input | 32 | General register word for loads |
| cr_q | output | 32 | Condition word |
| xer_q | output | 32 | Exception word: bit 31 SO, bit 30 OV, bit 29 CA |

## Verification
A wrong state in the summary-overflow machine shows on `xer_q` bit 31 on the edge after the bad transition. It can also show a later edge, in bit 28 of `cr_q`, when a record-form instruction copies it into field 0. A field written under the wrong index or mask appears at once as a nibble of `cr_q` that differs from the model. The bench compares both output words against its own model after every command, so each corruption is seen within one cycle of the command that causes it.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
    localparam int unsigned FIELD_W = 4;

    typedef enum logic [1:0] {
        OP_ALU        = 2'b00,
        OP_FIELD_COPY = 2'b01,
        OP_CR_LOAD    = 2'b10,
        OP_XER_LOAD   = 2'b11
    } cfu_op_e;

    typedef enum logic {
        SO_CLEAR = 1'b0,
        SO_SET   = 1'b1
    } so_state_e;
endpackage

// File: rtl/cfu_so_fsm.sv
module cfu_so_fsm
    import cfu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic load_evt,
    input  logic load_val,
    output logic so_q,
    output logic so_next
);
    so_state_e state_q, state_d;

    // next-state: raise, load-set, load-clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SO_CLEAR: begin
                if (load_evt)     state_d = load_val ? SO_SET : SO_CLEAR;
                else if (set_evt) state_d = SO_SET;
            end
            SO_SET: begin
                if (load_evt && !load_val) state_d = SO_CLEAR;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SO_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        so_q    = (state_q == SO_SET);
        so_next = (state_d == SO_SET);
    end

    p_so_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (so_q && !load_evt) |=> so_q);
    p_so_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && !load_evt) |=> so_q);
    p_so_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_evt |=> (so_q == $past(load_val)));
endmodule

// File: rtl/cfu_xer.sv
module cfu_xer #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_fire,
    input  logic              oe,
    input  logic              ovf,
    input  logic              ca_en,
    input  logic              carry,
    input  logic              load_evt,
    input  logic [2:0]        load_bits,
    output logic              so_next,
    output logic [DATA_W-1:0] xer_q
);
    localparam int unsigned PAD_W = DATA_W - 3;

    logic so_q, ov_q, ca_q;

    cfu_so_fsm u_so (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_evt  (alu_fire & oe & ovf),
        .load_evt (load_evt),
        .load_val (load_bits[2]),
        .so_q     (so_q),
        .so_next  (so_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov_q <= 1'b0;
            ca_q <= 1'b0;
        end else if (load_evt) begin
            ov_q <= load_bits[1];
            ca_q <= load_bits[0];
        end else if (alu_fire) begin
            if (oe)    ov_q <= ovf;
            if (ca_en) ca_q <= carry;
        end
    end

    assign xer_q = {so_q, ov_q, ca_q, {PAD_W{1'b0}}};

    p_ca_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fire && !ca_en) |=> $stable(ca_q));
    p_ca_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fire && ca_en) |=> (ca_q == $past(carry)));
    p_ov_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fire && !oe) |=> ($stable(ov_q) && $stable(so_q)));
    p_ov_track_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_fire && oe) |=> (ov_q == $past(ovf)));
endmodule

// File: rtl/cfu_cr.sv
module cfu_cr
    import cfu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            valid,
    input  cfu_op_e                         op,
    input  logic                            rc,
    input  logic [DATA_W-1:0]               result,
    input  logic                            so_next,
    input  logic [$clog2(DATA_W/FIELD_W)-1:0] src_sel,
    input  logic [$clog2(DATA_W/FIELD_W)-1:0] dst_sel,
    input  logic [DATA_W/FIELD_W-1:0]       mask,
    input  logic [DATA_W-1:0]               gpr,
    output logic [DATA_W-1:0]               cr_q
);
    localparam int unsigned N_FIELDS = DATA_W / FIELD_W;
    localparam int unsigned IDX_W    = $clog2(N_FIELDS);

    logic [N_FIELDS-1:0][FIELD_W-1:0] fld_q;
    logic [FIELD_W-1:0] src_val;
    logic [FIELD_W-1:0] cr0_new;
    logic               res_lt, res_eq;

    assign src_val = fld_q[src_sel];
    assign res_lt  = result[DATA_W-1];
    assign res_eq  = (result == '0);
    assign cr0_new = {res_lt, !res_lt && !res_eq, res_eq, so_next};

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        logic [FIELD_W-1:0] nxt;

        always_comb begin
            nxt = fld_q[i];
            if (valid) begin
                unique case (op)
                    OP_ALU:        if (rc && (i == 0)) nxt = cr0_new;
                    OP_FIELD_COPY: if (dst_sel == IDX_W'(i)) nxt = src_val;
                    OP_CR_LOAD:    if (mask[i]) nxt = gpr[DATA_W-1-FIELD_W*i -: FIELD_W];
                    OP_XER_LOAD:   ;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fld_q[i] <= '0;
            else        fld_q[i] <= nxt;
        end

        assign cr_q[DATA_W-1-FIELD_W*i -: FIELD_W] = fld_q[i];

        p_field_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (valid && op == OP_CR_LOAD && !mask[i]) |=> $stable(fld_q[i]));
    end

    p_cr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_ALU && !rc) |=> $stable(cr_q));
    p_cr0_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_ALU && rc) |=> ($countones(cr_q[DATA_W-1 -: 3]) == 1));
    p_cr0_so_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && op == OP_ALU && rc) |=> (cr_q[DATA_W-FIELD_W] == $past(so_next)));
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cfu_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 op_valid,
    input  logic [1:0]                           op_code,
    input  logic [DATA_W-1:0]                    alu_result,
    input  logic                                 alu_carry,
    input  logic                                 alu_ca_en,
    input  logic                                 alu_ovf,
    input  logic                                 alu_oe,
    input  logic                                 alu_rc,
    input  logic [$clog2(DATA_W/FIELD_W)-1:0]    src_field,
    input  logic [$clog2(DATA_W/FIELD_W)-1:0]    dst_field,
    input  logic [DATA_W/FIELD_W-1:0]            field_mask,
    input  logic [DATA_W-1:0]                    gpr_data,
    output logic [DATA_W-1:0]                    cr_q,
    output logic [DATA_W-1:0]                    xer_q
);
    cfu_op_e op;
    logic    alu_fire;
    logic    xer_load;
    logic    so_next;

    assign op       = cfu_op_e'(op_code);
    assign alu_fire = op_valid && (op == OP_ALU);
    assign xer_load = op_valid && (op == OP_XER_LOAD);

    cfu_xer #(.DATA_W(DATA_W)) u_xer (
        .clk       (clk),
        .rst_n     (rst_n),
        .alu_fire  (alu_fire),
        .oe        (alu_oe),
        .ovf       (alu_ovf),
        .ca_en     (alu_ca_en),
        .carry     (alu_carry),
        .load_evt  (xer_load),
        .load_bits (gpr_data[DATA_W-1 -: 3]),
        .so_next   (so_next),
        .xer_q     (xer_q)
    );

    cfu_cr #(.DATA_W(DATA_W)) u_cr (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (op_valid),
        .op      (op),
        .rc      (alu_rc),
        .result  (alu_result),
        .so_next (so_next),
        .src_sel (src_field),
        .dst_sel (dst_field),
        .mask    (field_mask),
        .gpr     (gpr_data),
        .cr_q    (cr_q)
    );

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(cr_q) && $stable(xer_q)));
    p_xer_pad_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xer_q[DATA_W-4:0] == '0));
endmodule

// File: tb/cond_flag_unit_test.sv
module cond_flag_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [31:0] alu_result = '0;
    logic        alu_carry = 1'b0, alu_ca_en = 1'b0, alu_ovf = 1'b0;
    logic        alu_oe = 1'b0, alu_rc = 1'b0;
    logic [2:0]  src_field = '0, dst_field = '0;
    logic [7:0]  field_mask = '0;
    logic [31:0] gpr_data = '0;
    logic [31:0] cr_q, xer_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_cr = '0;
    logic        m_so = 1'b0, m_ov = 1'b0, m_ca = 1'b0;

    always #4 clk = ~clk;

    cond_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .alu_result(alu_result), .alu_carry(alu_carry), .alu_ca_en(alu_ca_en),
        .alu_ovf(alu_ovf), .alu_oe(alu_oe), .alu_rc(alu_rc),
        .src_field(src_field), .dst_field(dst_field), .field_mask(field_mask),
        .gpr_data(gpr_data), .cr_q(cr_q), .xer_q(xer_q)
    );

    task automatic check_state(input string tag);
        logic [31:0] exp_xer;
        exp_xer = {m_so, m_ov, m_ca, 29'b0};
        checks++;
        if (cr_q !== m_cr || xer_q !== exp_xer) begin
            errors++;
            $display("FAIL %s: cr=%h xer=%h expected cr=%h xer=%h",
                     tag, cr_q, xer_q, m_cr, exp_xer);
        end
    endtask

    task automatic fire(input logic [1:0] code);
        op_code  = code;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic do_alu(input logic [31:0] res, input logic c, input logic cen,
                          input logic ov, input logic oe, input logic rc, input string tag);
        logic so_new;
        @(negedge clk);
        alu_result = res; alu_carry = c; alu_ca_en = cen;
        alu_ovf = ov; alu_oe = oe; alu_rc = rc;
        field_mask = 8'hFF; gpr_data = 32'hA5A5_5A5A; dst_field = 3'd5;
        fire(2'b00);
        so_new = m_so | (oe & ov);
        if (cen) m_ca = c;
        if (oe) m_ov = ov;
        m_so = so_new;
        if (rc) m_cr[31:28] = {$signed(res) < 0, $signed(res) > 0, res == 32'd0, so_new};
        check_state(tag);
    endtask

    task automatic do_copy(input logic [2:0] s, input logic [2:0] d, input string tag);
        logic [3:0] v;
        @(negedge clk);
        src_field = s; dst_field = d; field_mask = 8'hFF; gpr_data = '1;
        alu_oe = 1'b1; alu_ovf = 1'b1; alu_rc = 1'b1;
        fire(2'b01);
        v = m_cr[31-4*s -: 4];
        m_cr[31-4*d -: 4] = v;
        check_state(tag);
    endtask

    task automatic do_crload(input logic [7:0] m, input logic [31:0] g, input string tag);
        @(negedge clk);
        field_mask = m; gpr_data = g; alu_oe = 1'b1; alu_ovf = 1'b1; alu_rc = 1'b1;
        fire(2'b10);
        for (int n = 0; n < 8; n++)
            if (m[n]) m_cr[31-4*n -: 4] = g[31-4*n -: 4];
        check_state(tag);
    endtask

    task automatic do_xerload(input logic [31:0] g, input string tag);
        @(negedge clk);
        gpr_data = g; field_mask = 8'hFF; alu_rc = 1'b1;
        fire(2'b11);
        m_so = g[31]; m_ov = g[30]; m_ca = g[29];
        check_state(tag);
    endtask

    task automatic t_reset();
        check_state("R1 during reset");
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check_state("R1 after reset");
    endtask

    task automatic t_carry();
        do_alu(32'd5, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 carry set oe=0 (R11)");
        do_alu(32'd5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 carry held ca_en=0");
        do_alu(32'd5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R2 carry cleared oe=1");
        do_xerload(32'h0, "R9 clear before overflow test");
    endtask

    task automatic t_overflow();
        do_alu(32'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4 ovf ignored oe=0");
        do_alu(32'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R3 R4 ovf sets OV and SO");
        do_alu(32'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R4 OV cleared, R3 SO sticks");
        do_alu(32'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R3 SO sticks oe=0");
        do_copy(3'd2, 3'd3, "R3 SO sticks over copy");
        do_crload(8'h00, 32'h0, "R3 SO sticks over cr load");
    endtask

    task automatic t_record();
        do_alu(32'd9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 rc=0 cr unchanged");
        do_alu(32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6 negative with SO");
        do_alu(32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6 zero with SO");
        do_alu(32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6 positive with SO");
        do_xerload(32'h0, "R9 SO cleared by load");
        do_alu(32'h8000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R6 SO from same instruction");
        do_xerload(32'h0, "R9 clear again");
        do_alu(32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R6 zero without SO");
    endtask

    task automatic t_crload();
        do_crload(8'b1010_0101, 32'h1234_5678, "R8 partial mask");
        do_crload(8'hFF, 32'h9ABC_DEF0, "R8 full mask");
        do_crload(8'h00, 32'hFFFF_FFFF, "R8 empty mask");
        do_alu(32'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R5 ALU leaves fields 1-7");
    endtask

    task automatic t_copy();
        do_copy(3'd1, 3'd6, "R7 copy 1 to 6");
        do_copy(3'd7, 3'd0, "R7 copy 7 to 0");
        do_copy(3'd4, 3'd4, "R7 copy onto itself");
        do_copy(3'd0, 3'd3, "R7 copy 0 to 3");
    endtask

    task automatic t_xerload();
        do_xerload(32'hFFFF_FFFF, "R9 all ones, pad reads 0");
        do_xerload(32'h4000_0000, "R9 only OV");
        do_xerload(32'h2000_0000, "R9 only CA");
    endtask

    task automatic t_idle();
        do_xerload(32'hE000_0000, "R9 preset before idle");
        @(negedge clk);
        op_code = 2'b10; field_mask = 8'hFF; gpr_data = 32'h0;
        alu_result = 32'h0; alu_rc = 1'b1; alu_oe = 1'b1;
        repeat (3) @(negedge clk);
        check_state("R10 idle cr load");
        op_code = 2'b11;
        repeat (2) @(negedge clk);
        check_state("R10 idle xer load");
    endtask

    initial begin
        t_reset();
        t_carry();
        t_overflow();
        t_record();
        t_crload();
        t_copy();
        t_xerload();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual not done expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule